// File: doc/BRIEF.md
# Gated Transmit PCM Serial Port

This block is the transmit half of a codec serial port. An encoder supplies a parallel PCM word. The word is captured into a rotating shift register on an internal strobe. The strobe comes from the first rising edge of the transmit enable that follows a rising edge of the frame sync. The same strobe is also sent out as a one-cycle conversion-start pulse. The word then leaves the block on a serial data line, sign bit first. It moves one bit on each rising edge of the data clock that arrives while the enable is high.

The enable does two jobs. It gates the shift clock, and it drives the output-enable of the external three-state pad. The register rotates rather than emptying, so a word can be read more than once per frame. The enable may also be dropped and raised again inside a word for bit-interleaved access; shifting resumes from the bit where it stopped. The block watches the spacing between frames. It flags a new frame that begins before enough data clock falling edges have passed since the last enable rise.

All pins are sampled by a system clock that runs much faster than the data clock. Every pin passes through a two-stage sampling pipe, and the edges are detected from that pipe. Every reaction appears two system clocks after the pin change that caused it.

Top module: `tx_pcm_port`

## Requirements
- R1: While reset is held and right after it, `tx_data`, `tx_oe`, `conv_start` and `spacing_err` are all 0.
- R2: A rising edge on `tx_en` that follows at least one rising edge of `msync` since the previous strobe produces a strobe. The strobe raises `conv_start` for exactly one system clock. Further `tx_en` rising edges without a new `msync` rising edge produce no strobe.
- R3: On a strobe the word on `pcm_word` is captured, and `tx_data` presents its bit 7 (the sign bit) first.
- R4: Each rising edge of `dclk` seen while `tx_en` is high advances `tx_data` to the next lower bit. Rising edges of `dclk` while `tx_en` is low leave `tx_data` unchanged.
- R5: `tx_oe` equals the level of `tx_en` two system clocks earlier. It is high exactly while the data pad must be driven.
- R6: After bit 0, the next gated `dclk` rising edge shows bit 7 again, and the same word repeats for as long as shifting continues.
- R7: When `tx_en` drops inside a word and rises again with no new `msync` edge, shifting continues from the bit that was showing.
- R8: `spacing_err` pulses for one cycle, together with `conv_start`, when fewer than 2 `dclk` falling edges have occurred since the previous `tx_en` rising edge. Exactly 2 or more falling edges, or no earlier enable rise since reset, give no pulse.
- R9: Changes on `pcm_word` after a strobe do not affect the bits being shifted until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than `dclk` |
| rst_n | input | 1 | Active-low reset |
| dclk | input | 1 | Serial data clock |
| tx_en | input | 1 | Transmit enable: shift gate and pad drive control |
| msync | input | 1 | Frame sync that arms the next strobe |
| pcm_word | input | 8 | Parallel PCM word from the encoder |
| tx_data | output | 1 | Serial data bit |
| tx_oe | output | 1 | Output-enable for the external three-state pad |
| conv_start | output | 1 | One-cycle conversion-start / load strobe |
| spacing_err | output | 1 | One-cycle pulse on a frame started too soon |

## Verification
The bench runs a full word and then a second pass over the same word. A design that cleared the register instead of rotating it would show zeros on the second pass. It drops the enable in mid-word and clocks `dclk` while the enable is low. A design that shifted without the gate, or restarted the word on the new enable edge, would show the wrong bit when shifting resumes. It changes `pcm_word` right after the load, to catch a design that reads the word live rather than holding it. The spacing rule is driven exactly at its limit (two falling edges, no flag) and one edge short (flag). An off-by-one counter would misreport one side of that limit. A second enable rise with no new sync must not produce a strobe.

// File: rtl/tx_pcm_pkg.sv
package tx_pcm_pkg;

    // Per-channel variant picked in the input sampling pipe
    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_LEVEL = 2'd2
    } edge_mode_e;

    // Channel positions inside the sampled input vector
    localparam int CH_SYNC_RISE = 0;
    localparam int CH_EN_RISE   = 1;
    localparam int CH_EN_LEVEL  = 2;
    localparam int CH_DC_RISE   = 3;
    localparam int CH_DC_FALL   = 4;
    localparam int NUM_CH       = 5;

endpackage

// File: rtl/tx_pcm_edge_det.sv
module tx_pcm_edge_det #(
    parameter int                 N     = 5,
    parameter logic [2*N-1:0]     MODES = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] evt
);
    import tx_pcm_pkg::*;

    typedef struct packed {
        logic [N-1:0] smp;
        logic [N-1:0] prev;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.smp  = raw;
        pipe_d.prev = pipe_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_ch
        localparam logic [1:0] MODE = MODES[2*i +: 2];
        if (MODE == EDGE_RISE) begin : g_rise
            assign evt[i] = pipe_q.smp[i] & ~pipe_q.prev[i];
        end else if (MODE == EDGE_FALL) begin : g_fall
            assign evt[i] = ~pipe_q.smp[i] & pipe_q.prev[i];
        end else begin : g_level
            assign evt[i] = pipe_q.prev[i];
        end
    end

endmodule

// File: rtl/tx_pcm_frame_ctrl.sv
module tx_pcm_frame_ctrl #(
    parameter int SPACING_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rise,
    input  logic en_rise,
    input  logic dc_fall,
    output logic load,
    output logic start,
    output logic err
);
    localparam int              CNT_W   = $clog2(SPACING_MIN + 1);
    localparam logic [CNT_W-1:0] GAP_SAT = CNT_W'(SPACING_MIN);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] gap;
        logic             start;
        logic             err;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    assign load = en_rise & ctrl_q.armed;

    always_comb begin
        ctrl_d = ctrl_q;

        // arming: a new sync edge prepares the next enable edge
        if (load) begin
            ctrl_d.armed = 1'b0;
        end
        if (sync_rise) begin
            ctrl_d.armed = 1'b1;
        end

        // falling data clock edges since the latest enable rise, saturating
        if (en_rise) begin
            ctrl_d.gap = '0;
        end else if (dc_fall && (ctrl_q.gap < GAP_SAT)) begin
            ctrl_d.gap = ctrl_q.gap + 1'b1;
        end

        ctrl_d.start = load;
        ctrl_d.err   = load && (ctrl_q.gap < GAP_SAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.gap   <= GAP_SAT;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign start = ctrl_q.start;
    assign err   = ctrl_q.err;

endmodule

// File: rtl/tx_pcm_shifter.sv
module tx_pcm_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word,
    output logic              sdata
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.sh = word;
        end else if (shift) begin
            // rotate so the sign bit comes back after the last bit
            sh_d.sh = {sh_q.sh[WORD_W-2:0], sh_q.sh[WORD_W-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdata = sh_q.sh[WORD_W-1];

endmodule

// File: rtl/tx_pcm_port.sv
module tx_pcm_port #(
    parameter int WORD_W      = 8,
    parameter int SPACING_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dclk,
    input  logic              tx_en,
    input  logic              msync,
    input  logic [WORD_W-1:0] pcm_word,
    output logic              tx_data,
    output logic              tx_oe,
    output logic              conv_start,
    output logic              spacing_err
);
    import tx_pcm_pkg::*;

    localparam logic [2*NUM_CH-1:0] CH_MODES = {
        EDGE_FALL,   // CH_DC_FALL
        EDGE_RISE,   // CH_DC_RISE
        EDGE_LEVEL,  // CH_EN_LEVEL
        EDGE_RISE,   // CH_EN_RISE
        EDGE_RISE    // CH_SYNC_RISE
    };

    logic [NUM_CH-1:0] raw;
    logic [NUM_CH-1:0] evt;
    logic              load;
    logic              shift;

    assign raw = {dclk, dclk, tx_en, tx_en, msync};

    tx_pcm_edge_det #(
        .N     (NUM_CH),
        .MODES (CH_MODES)
    ) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .evt   (evt)
    );

    tx_pcm_frame_ctrl #(
        .SPACING_MIN (SPACING_MIN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_rise (evt[CH_SYNC_RISE]),
        .en_rise   (evt[CH_EN_RISE]),
        .dc_fall   (evt[CH_DC_FALL]),
        .load      (load),
        .start     (conv_start),
        .err       (spacing_err)
    );

    // shift clock is the data clock gated by the enable
    assign shift = evt[CH_DC_RISE] & evt[CH_EN_LEVEL];

    tx_pcm_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .word  (pcm_word),
        .sdata (tx_data)
    );

    assign tx_oe = evt[CH_EN_LEVEL];

endmodule

// File: rtl/tx_pcm_port_chk.sv
module tx_pcm_port_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tx_oe,
    input logic tx_data,
    input logic conv_start,
    input logic spacing_err
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_err_with_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spacing_err |-> conv_start);

    p_oe_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (tx_oe == $past(tx_en, 2)));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q != 2'd0) && !$past(tx_oe)) |-> ($stable(tx_data) || conv_start));

endmodule

bind tx_pcm_port tx_pcm_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .tx_oe       (tx_oe),
    .tx_data     (tx_data),
    .conv_start  (conv_start),
    .spacing_err (spacing_err)
);

// File: tb/sim_tx_pcm_port.sv
module sim_tx_pcm_port;

    typedef struct {
        string req;
        logic  val;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dclk = 1'b0;
    logic       tx_en = 1'b0;
    logic       msync = 1'b0;
    logic [7:0] pcm_word = 8'h00;
    logic       tx_data, tx_oe, conv_start, spacing_err;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   n_start = 0;
    int   n_err   = 0;
    bit   done    = 1'b0;
    exp_t exp_q[$];
    event obs_ev;

    always #2 clk = ~clk;

    tx_pcm_port u0 (
        .clk(clk), .rst_n(rst_n), .dclk(dclk), .tx_en(tx_en), .msync(msync),
        .pcm_word(pcm_word), .tx_data(tx_data), .tx_oe(tx_oe),
        .conv_start(conv_start), .spacing_err(spacing_err)
    );

    always @(posedge clk) begin
        if (conv_start)  n_start++;
        if (spacing_err) n_err++;
    end

    task automatic check(bit ok, string req, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard driver side: push the expected serial bit, then let the monitor compare
    task automatic expect_bit(string req, logic v);
        exp_t e;
        e.req = req;
        e.val = v;
        exp_q.push_back(e);
        -> obs_ev;
        wait_n(1);
    endtask

    initial begin : monitor
        forever begin
            @(obs_ev);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(tx_data === e.val, e.req, int'(tx_data), int'(e.val));
            end
        end
    end

    task automatic dclk_cycle();
        dclk = 1'b1; wait_n(4);
        dclk = 1'b0; wait_n(4);
    endtask

    task automatic sync_pulse();
        msync = 1'b1; wait_n(3);
        msync = 1'b0; wait_n(2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] wa, wc, wd;
        int         pos;
        int         s0, e0;
        wa = 8'hB4;
        wc = 8'h5A;
        wd = 8'h3C;

        // R1 reset state
        wait_n(5);
        check(tx_data == 1'b0 && tx_oe == 1'b0, "R1 data/oe in reset", {tx_data, tx_oe}, 0);
        check(conv_start == 1'b0 && spacing_err == 1'b0, "R1 pulses in reset",
              {conv_start, spacing_err}, 0);
        rst_n = 1'b1;
        wait_n(3);
        check(tx_data == 1'b0 && tx_oe == 1'b0, "R1 after release", {tx_data, tx_oe}, 0);

        // frame A: sync, then enable rise
        pcm_word = wa;
        sync_pulse();
        s0 = n_start; e0 = n_err;
        tx_en = 1'b1;
        wait_n(4);
        check(n_start == s0 + 1, "R2 strobe on first enable rise", n_start - s0, 1);
        check(n_err == e0, "R8 no flag after reset", n_err - e0, 0);
        check(tx_oe == 1'b1, "R5 oe high with enable", tx_oe, 1);
        expect_bit("R3 sign bit first", wa[7]);
        pcm_word = 8'h00;  // R9: must not disturb the captured word

        pos = 7;
        for (int k = 1; k <= 16; k++) begin
            dclk = 1'b1; wait_n(4);
            pos = (pos + 7) % 8;
            expect_bit(k <= 8 ? "R4 gated shift" : "R6 recirculated R9 held word", wa[pos]);
            dclk = 1'b0; wait_n(3);
        end
        check(n_start == s0 + 1, "R2 no extra strobe while enabled", n_start - s0, 1);

        // R7 bit-interleaved access
        for (int k = 0; k < 3; k++) begin
            dclk = 1'b1; wait_n(4);
            pos = (pos + 7) % 8;
            expect_bit("R7 before pause", wa[pos]);
            dclk = 1'b0; wait_n(3);
        end
        tx_en = 1'b0;
        wait_n(4);
        check(tx_oe == 1'b0, "R5 oe low with enable low", tx_oe, 0);
        for (int k = 0; k < 2; k++) begin
            dclk = 1'b1; wait_n(4);
            expect_bit("R4 ungated edge holds bit", wa[pos]);
            dclk = 1'b0; wait_n(3);
        end
        s0 = n_start;
        tx_en = 1'b1;
        wait_n(4);
        check(n_start == s0, "R2 no strobe without sync", n_start - s0, 0);
        expect_bit("R7 resume position", wa[pos]);
        for (int k = 0; k < 5; k++) begin
            dclk = 1'b1; wait_n(4);
            pos = (pos + 7) % 8;
            expect_bit("R7 after resume", wa[pos]);
            dclk = 1'b0; wait_n(3);
        end

        // R8 boundary: exactly two falling edges
        tx_en = 1'b0; wait_n(4);
        tx_en = 1'b1; wait_n(4);
        sync_pulse();
        tx_en = 1'b0; wait_n(4);
        dclk_cycle();
        dclk_cycle();
        pcm_word = wc;
        s0 = n_start; e0 = n_err;
        tx_en = 1'b1;
        wait_n(4);
        check(n_start == s0 + 1, "R2 strobe frame C", n_start - s0, 1);
        check(n_err == e0, "R8 two edges legal", n_err - e0, 0);
        expect_bit("R3 frame C sign bit", wc[7]);
        dclk = 1'b1; wait_n(4);
        expect_bit("R4 frame C bit 6", wc[6]);
        dclk = 1'b0; wait_n(3);

        // R8 violation: one falling edge only
        tx_en = 1'b0; wait_n(4);
        tx_en = 1'b1; wait_n(4);
        sync_pulse();
        tx_en = 1'b0; wait_n(4);
        dclk_cycle();
        pcm_word = wd;
        s0 = n_start; e0 = n_err;
        tx_en = 1'b1;
        wait_n(4);
        check(n_start == s0 + 1, "R2 strobe frame D", n_start - s0, 1);
        check(n_err == e0 + 1, "R8 one edge flagged once", n_err - e0, 1);
        expect_bit("R3 frame D sign bit", wd[7]);

        tx_en = 1'b0;
        wait_n(4);
        check(tx_oe == 1'b0, "R5 oe low at end", tx_oe, 0);
        wait_n(2);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule